// File: doc/BRIEF.md
# Fault Latch and Soft-Start Restart Sequencer

This block decides when a switching power controller may drive its power switches after a fault. Three fault sources feed it: an overcurrent trip from the current-sense comparator, an undervoltage lockout derived from a digitized supply code with hysteresis, and a flag that reports whether the internal reference is healthy. A digital soft-start level takes the place of the soft-start capacitor. It is an up/down counter that moves by one count on each step enable, with the same step size in both directions.

After reset the level charges up from zero. A fault can latch only once the level has reached the completion threshold. A latched fault holds the drivers off and discharges the level down to the restart threshold. The latch then releases and the level charges again. Because a fault cannot start a discharge before the previous ramp has finished, continuous faults restart no faster than one full soft-start period. Downstream logic uses the level to limit the duty command during ramp-up, and uses the inhibit output to force both drivers low.

Top module: `fault_ss_seq`

## Requirements
- R1: The fault request is the OR of `oc_trip`, the undervoltage lock and a low `ref_good`. Once a request latches, `drv_inhibit` is high in the cycle after the clock edge that saw it.
- R2: `ss_level` resets to 0. It changes only on a clock edge where `step_en` is high, and by exactly one count per such edge.
- R3: The fault latch sets only while `ss_level` is at or above `SS_DONE` (48 by default). A fault request that arrives during ramp-up therefore latches at the first edge after the level reaches 48, when the level reads 49.
- R4: While discharging, the level never goes below `SS_RESTART` (16 by default). With `step_en` high on every cycle, the peak of a fault cycle is `SS_DONE`+2.
- R5: The latch releases only when the level has reached `SS_RESTART`. After that the level charges by one per step. A latched fault always completes its discharge, even if every fault source clears.
- R6: Charge and discharge use equal steps. Under a continuous overcurrent with `step_en` always high, the inhibit pulse lasts `SS_DONE`-`SS_RESTART`+4 cycles and the restart period is 2·(`SS_DONE`-`SS_RESTART`)+5 cycles.
- R7: `drv_inhibit` is high whenever the fault latch is set or `uv_lock` is high. It is also high in reset.
- R8: With `uv_prog_sel`=1, a locked supply unlocks on the edge where `sup_code` ≥ 120, and an unlocked supply locks on the edge where `sup_code` < 100.
- R9: With `uv_prog_sel`=0, the thresholds are 140 to unlock and 90 to lock.
- R10: While charging, the level saturates at its full scale of 63 and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Soft-start step enable (one count per edge) |
| oc_trip | input | 1 | Overcurrent comparator trip |
| ref_good | input | 1 | Reference healthy flag |
| sup_code | input | SUP_W (8) | Digitized supply / divider code |
| uv_prog_sel | input | 1 | 1: programmed-divider thresholds, 0: default supply thresholds |
| drv_inhibit | output | 1 | Forces the output drivers low |
| uv_lock | output | 1 | Undervoltage lockout state |
| ss_level | output | SS_W (6) | Soft-start level |

## Verification
On every cycle the assertions check the following: the level moves by at most one count and only on a step; the fault latch cannot set below the completion threshold; a discharge never goes under the restart level; a set latch stays set until that level is reached; and the lockout holds its state inside the hysteresis band. Other behaviours show up only in the bench scenarios. These are the exact peak and trough of a fault cycle, the inhibit pulse length and the restart period under a continuous overcurrent, and the completed discharge after a reference dip has already cleared. The bench also sweeps every supply code from both lockout states in both threshold modes.

// File: rtl/fault_ss_pkg.sv
package fault_ss_pkg;
   typedef enum logic {
      DIR_CHARGE    = 1'b0,
      DIR_DISCHARGE = 1'b1
   } ss_dir_e;
endpackage

// File: rtl/uvlo_hyst.sv
module uvlo_hyst #(
   parameter int SUP_W  = 8,
   parameter int ON_PRG = 120,
   parameter int OFF_PRG = 100,
   parameter int ON_DEF = 140,
   parameter int OFF_DEF = 90
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SUP_W-1:0] sup_code,
   input  logic             prog_sel,
   output logic             lock
);
   localparam logic [SUP_W-1:0] ON_P  = SUP_W'(ON_PRG);
   localparam logic [SUP_W-1:0] OFF_P = SUP_W'(OFF_PRG);
   localparam logic [SUP_W-1:0] ON_D  = SUP_W'(ON_DEF);
   localparam logic [SUP_W-1:0] OFF_D = SUP_W'(OFF_DEF);

   if (OFF_PRG >= ON_PRG || OFF_DEF >= ON_DEF) begin : g_bad_hyst
      $error("uvlo_hyst: lock threshold must be below unlock threshold");
   end
   if (ON_PRG >= (1 << SUP_W) || ON_DEF >= (1 << SUP_W)) begin : g_bad_width
      $error("uvlo_hyst: threshold does not fit SUP_W");
   end

   logic [SUP_W-1:0] on_thr, off_thr;
   always_comb begin
      on_thr  = prog_sel ? ON_P  : ON_D;
      off_thr = prog_sel ? OFF_P : OFF_D;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            lock <= 1'b1;
      else if (lock && sup_code >= on_thr)   lock <= 1'b0;
      else if (!lock && sup_code < off_thr)  lock <= 1'b1;
   end

   AST_UV_HOLD_PRG: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_sel && lock && sup_code < ON_P) |=> lock); // R8
   AST_UV_KEEP_PRG: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_sel && !lock && sup_code >= OFF_P) |=> !lock); // R8
   AST_UV_HOLD_DEF: assert property (@(posedge clk) disable iff (!rst_n)
      (!prog_sel && lock && sup_code < ON_D) |=> lock); // R9
   AST_UV_KEEP_DEF: assert property (@(posedge clk) disable iff (!rst_n)
      (!prog_sel && !lock && sup_code >= OFF_D) |=> !lock); // R9
endmodule

// File: rtl/ss_ramp.sv
module ss_ramp
   import fault_ss_pkg::*;
#(
   parameter int SS_W       = 6,
   parameter int SS_RESTART = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            step_en,
   input  ss_dir_e         dir,
   output logic [SS_W-1:0] level
);
   localparam logic [SS_W-1:0] FULL  = {SS_W{1'b1}};
   localparam logic [SS_W-1:0] FLOOR = SS_W'(SS_RESTART);

   if (SS_W < 2) begin : g_bad_w
      $error("ss_ramp: SS_W too small");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level <= '0;
      end else if (step_en) begin
         if (dir == DIR_DISCHARGE) begin
            if (level > FLOOR) level <= level - 1'b1;
         end else if (level != FULL) begin
            level <= level + 1'b1;
         end
      end
   end

   AST_STEP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !step_en |=> $stable(level)); // R2
   AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (level == $past(level) || level == $past(level) + 1'b1
                || level == $past(level) - 1'b1)); // R2
   AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (level == FULL && dir == DIR_CHARGE) |=> level == FULL); // R10
endmodule

// File: rtl/fault_latch_ctl.sv
module fault_latch_ctl
   import fault_ss_pkg::*;
#(
   parameter int SS_W       = 6,
   parameter int SS_DONE    = 48,
   parameter int SS_RESTART = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            fault_req,
   input  logic [SS_W-1:0] level,
   output logic            flt,
   output ss_dir_e         dir
);
   localparam logic [SS_W-1:0] DONE_L = SS_W'(SS_DONE);
   localparam logic [SS_W-1:0] RST_L  = SS_W'(SS_RESTART);

   if (SS_RESTART >= SS_DONE || SS_DONE >= (1 << SS_W)) begin : g_bad_thr
      $error("fault_latch_ctl: need SS_RESTART < SS_DONE < 2**SS_W");
   end

   logic dly, complete, at_floor, release_c;
   always_comb begin
      complete  = level >= DONE_L;
      at_floor  = level <= RST_L;
      release_c = flt && dly && at_floor;
      dir       = dly ? DIR_DISCHARGE : DIR_CHARGE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flt <= 1'b0;
         dly <= 1'b0;
      end else begin
         flt <= release_c ? 1'b0 : (flt || (fault_req && complete));
         dly <= flt && !release_c;
      end
   end

   AST_SET_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (!flt && level < DONE_L) |=> !flt); // R3
   AST_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      dly |-> level >= RST_L); // R4
   AST_HOLD_TO_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      (flt && level > RST_L) |=> flt); // R5
   AST_REQ_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_req && level >= DONE_L) |=> flt); // R1
endmodule

// File: rtl/fault_ss_seq.sv
module fault_ss_seq
   import fault_ss_pkg::*;
#(
   parameter int SS_W       = 6,
   parameter int SS_DONE    = 48,
   parameter int SS_RESTART = 16,
   parameter int SUP_W      = 8,
   parameter int UV_ON_PRG  = 120,
   parameter int UV_OFF_PRG = 100,
   parameter int UV_ON_DEF  = 140,
   parameter int UV_OFF_DEF = 90
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_en,
   input  logic             oc_trip,
   input  logic             ref_good,
   input  logic [SUP_W-1:0] sup_code,
   input  logic             uv_prog_sel,
   output logic             drv_inhibit,
   output logic             uv_lock,
   output logic [SS_W-1:0]  ss_level
);
   logic    flt, fault_req;
   ss_dir_e dir;

   uvlo_hyst #(
      .SUP_W(SUP_W), .ON_PRG(UV_ON_PRG), .OFF_PRG(UV_OFF_PRG),
      .ON_DEF(UV_ON_DEF), .OFF_DEF(UV_OFF_DEF)
   ) u_uvlo (
      .clk(clk), .rst_n(rst_n), .sup_code(sup_code),
      .prog_sel(uv_prog_sel), .lock(uv_lock)
   );

   always_comb fault_req = oc_trip || uv_lock || !ref_good;

   fault_latch_ctl #(
      .SS_W(SS_W), .SS_DONE(SS_DONE), .SS_RESTART(SS_RESTART)
   ) u_latch (
      .clk(clk), .rst_n(rst_n), .fault_req(fault_req),
      .level(ss_level), .flt(flt), .dir(dir)
   );

   ss_ramp #(
      .SS_W(SS_W), .SS_RESTART(SS_RESTART)
   ) u_ramp (
      .clk(clk), .rst_n(rst_n), .step_en(step_en),
      .dir(dir), .level(ss_level)
   );

   always_comb drv_inhibit = flt || uv_lock;

   AST_INHIBIT_ON_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (ss_level >= SS_W'(SS_DONE) && !ref_good) |=> drv_inhibit); // R7
endmodule

// File: tb/fault_ss_seq_test.sv
module fault_ss_seq_test;
   localparam int CLK_PERIOD = 10;
   localparam int D = 48;
   localparam int RS = 16;
   localparam int FULL = 63;

   logic clk = 1'b0;
   logic rst_n, step_en, oc_trip, ref_good, uv_prog_sel;
   logic [7:0] sup_code;
   logic drv_inhibit, uv_lock;
   logic [5:0] ss_level;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fault_ss_seq uut (
      .clk(clk), .rst_n(rst_n), .step_en(step_en), .oc_trip(oc_trip),
      .ref_good(ref_good), .sup_code(sup_code), .uv_prog_sel(uv_prog_sel),
      .drv_inhibit(drv_inhibit), .uv_lock(uv_lock), .ss_level(ss_level)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      #2;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) cyc();
      rst_n = 1'b1;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int hi, lo, mx;
      step_en = 1'b1; oc_trip = 1'b0; ref_good = 1'b1;
      sup_code = 8'd200; uv_prog_sel = 1'b1;
      rst_n = 1'b0;
      repeat (3) cyc();
      chk(ss_level == 0, "R2 reset level", ss_level, 0);
      chk(drv_inhibit == 1, "R7 reset inhibit", drv_inhibit, 1);
      chk(uv_lock == 1, "R8 reset lock", uv_lock, 1);
      rst_n = 1'b1;

      // charge ramp from zero, saturation at full scale
      for (int n = 1; n <= 70; n++) begin
         cyc();
         chk(ss_level == ((n < FULL) ? n : FULL), "R2/R10 ramp level", ss_level,
             (n < FULL) ? n : FULL);
         if (n == 1) begin
            chk(uv_lock == 0, "R8 unlock", uv_lock, 0);
            chk(drv_inhibit == 0, "R7 no inhibit", drv_inhibit, 0);
         end
      end
      step_en = 1'b0;
      for (int n = 0; n < 5; n++) begin
         cyc();
         chk(ss_level == FULL, "R2 frozen without step", ss_level, FULL);
      end
      step_en = 1'b1;

      // one-cycle reference dip: full discharge still completes
      ref_good = 1'b0;
      cyc();
      chk(drv_inhibit == 1, "R1 ref dip latches", drv_inhibit, 1);
      ref_good = 1'b1;
      hi = 1;
      for (int g = 0; g < 200 && drv_inhibit; g++) begin
         cyc();
         if (drv_inhibit) hi++;
      end
      chk(hi == FULL - RS + 2, "R5 discharge duration", hi, FULL - RS + 2);
      chk(ss_level == RS, "R5 release level", ss_level, RS);
      cyc();
      chk(ss_level == RS + 1, "R5 charge resumes", ss_level, RS + 1);

      // continuous overcurrent from mid-ramp
      do_reset();
      repeat (20) cyc();
      chk(ss_level == 20, "R2 mid ramp", ss_level, 20);
      oc_trip = 1'b1;
      for (int g = 0; g < 200 && !drv_inhibit; g++) begin
         if (ss_level < D - 1)
            chk(drv_inhibit == 0, "R3 gated before done", drv_inhibit, 0);
         cyc();
      end
      chk(ss_level == D + 1, "R3 latch point", ss_level, D + 1);
      for (int rep = 0; rep < 2; rep++) begin
         hi = 0; mx = 0;
         for (int g = 0; g < 300 && drv_inhibit; g++) begin
            hi++;
            if (ss_level > mx) mx = ss_level;
            chk(ss_level >= RS, "R4 floor", ss_level, RS);
            cyc();
         end
         chk(mx == D + 2, "R4 peak", mx, D + 2);
         chk(ss_level == RS, "R5 trough", ss_level, RS);
         chk(hi == D - RS + 4, "R6 inhibit length", hi, D - RS + 4);
         lo = 0;
         for (int g = 0; g < 300 && !drv_inhibit; g++) begin
            lo++;
            cyc();
         end
         chk(hi + lo == 2 * (D - RS) + 5, "R6 restart period", hi + lo, 2 * (D - RS) + 5);
      end
      oc_trip = 1'b0;

      // UVLO sweep, both modes, both prior states
      for (int m = 0; m < 2; m++) begin
         uv_prog_sel = m[0];
         for (int p = 0; p < 2; p++) begin
            for (int c = 0; c < 256; c++) begin
               int on_t, off_t, e;
               on_t  = m ? 120 : 140;
               off_t = m ? 100 : 90;
               sup_code = (p == 0) ? 8'd0 : 8'd255;
               cyc();
               sup_code = c[7:0];
               cyc();
               e = (p == 0) ? ((c < on_t) ? 1 : 0) : ((c < off_t) ? 1 : 0);
               chk(uv_lock == e[0], m ? "R8 prog threshold" : "R9 default threshold",
                   uv_lock, e);
               if (e == 1) chk(drv_inhibit == 1, "R7 inhibit under lock", drv_inhibit, 1);
            end
         end
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule